// File: doc/BRIEF.md
# External Bus Strobe Controller

This block turns internal access requests from a 16-bit processor core into the control strobes of an external memory bus. A requester presents an address, a read/write flag, a byte-or-word size flag and write data, and holds its request until the controller reports completion. Each access runs as a fixed sequence of phases. An address phase pulses the address latch enable and drives the chip selects. A strobe phase drives the read or write strobes and can be stretched by a ready input. A terminate phase releases the strobes and reports completion, carrying read data when the access was a read.

Two strobe encodings are chosen per access by a configuration bit. In split mode, intended for a 16-bit data bus, two separate write strobes cover the low (even) byte and the high (odd) byte. In combined mode, intended for an 8-bit data bus, one write strobe marks any write and a byte-high enable marks an access that includes the odd byte. A read strobe marks reads in both modes. The eight high address bits go out with the top bit inverted. Four chip-select windows are decoded from base/mask pairs on those high bits. An external master can ask for the bus with an active-low hold input. The controller grants it only between accesses, acknowledges with an active-low hold-acknowledge, and turns off its output enables for as long as the hold lasts.

Top module: `ext_bus_strobe_ctrl`

## Requirements
- R1: While reset is high, and after it: rd_n, wr_lo_n and wr_hi_n are 1, ale is 0, all cs_n bits are 1, hlda_n is 1, done is 0, addr_oe and strb_oe are 1, and data_oe is 0.
- R2: When req_valid is seen high in idle with hold_n high, ale is 1 for exactly the next clock (address phase), and a_lo shows the low 16 address bits. The strobe phase follows one clock later.
- R3: In split mode (cfg_combined=0), during the strobe phase of a write, wr_lo_n=0 only when the even byte is written and wr_hi_n=0 only when the odd byte is written. A byte write to an even address (req_addr[0]=0) lowers only wr_lo_n, a byte write to an odd address lowers only wr_hi_n, and a word write (req_word=1) lowers both.
- R4: In combined mode (cfg_combined=1), wr_lo_n acts as the single write strobe and is 0 during the strobe phase of every write. wr_hi_n acts as byte-high enable and is 0 from the address phase through the terminate phase of any read or write that includes the odd byte (odd byte address or word).
- R5: For a read in either mode, rd_n is 0 during the strobe phase and no write strobe is low. The value on bus_din at the last strobe clock appears on rd_data while done is 1.
- R6: rdy_n is sampled at the end of each strobe clock. Each sampled 0 adds one more strobe clock with the strobes held.
- R7: When hold_n is 0 in idle, hold has priority over a pending request. From the next clock, hlda_n is 0, addr_oe, strb_oe and data_oe are 0, all strobes are 1, all cs_n are 1 and ale is 0, for as long as hold_n stays 0. One clock after hold_n returns to 1, the controller is idle again.
- R8: A hold request that arrives during an access does not shorten it. The access completes with done, and hlda_n falls only after the controller has passed through idle.
- R9: a_hi equals the top eight address bits with the most significant bit inverted: {~A[23], A[22:16]}.
- R10: Window i (i=0..3) matches when (A[23:16] & mask_i) == base_i, where base_i and mask_i sit at bits [8i+7:8i] of win_base and win_mask. The lowest matching index drives its cs_n bit to 0 from the address phase through terminate. With no match, all cs_n bits stay 1.
- R11: done is 1 for exactly one clock per access, during the terminate phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until done |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 16 | Write data, already placed on its byte lane |
| cfg_combined | input | 1 | 0 = split write strobes, 1 = single write strobe plus byte-high enable |
| win_base | input | 32 | Four 8-bit window base values |
| win_mask | input | 32 | Four 8-bit window masks |
| hold_n | input | 1 | Active-low bus hold request |
| rdy_n | input | 1 | Active-low wait request, sampled in strobe phase |
| bus_din | input | 16 | External read data |
| done | output | 1 | Access complete pulse |
| rd_data | output | 16 | Captured read data |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Low-byte write strobe (split) or write strobe (combined) |
| wr_hi_n | output | 1 | High-byte write strobe (split) or byte-high enable (combined) |
| ale | output | 1 | Address latch enable |
| cs_n | output | 4 | Chip selects, active low |
| a_hi | output | 8 | High address bits, top bit inverted |
| a_lo | output | 16 | Low address bits |
| bus_dout | output | 16 | Write data to the external bus |
| addr_oe | output | 1 | Address output enable |
| data_oe | output | 1 | Data output enable |
| strb_oe | output | 1 | Strobe and chip-select output enable |
| hlda_n | output | 1 | Hold acknowledge, active low |

## Verification
The hardest case to reach is a hold request that lands in the middle of an access. It must neither cut the access short nor be lost, so hold_n has to fall exactly while the address phase is on the pins. The bench counts clocks from the request and lowers hold_n at the negative edge where ale is high. It then checks that the strobe and terminate phases still run, that hlda_n stays high through the idle clock after done, and that it falls one clock later. The wait-state vectors lower rdy_n before the strobe phase and raise it after a counted number of strobe clocks, so the stretched length is known exactly.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_STRB = 3'd2,
    ST_TERM = 3'd3,
    ST_HOLD = 3'd4
  } ebc_state_e;

  typedef struct packed {
    logic       write;
    logic       combined;
    logic [1:0] be;
  } ebc_ctl_t;

  typedef struct packed {
    logic rd_n;
    logic wlo_n;
    logic whi_n;
    logic ale;
    logic hlda_n;
    logic bus_oe;
    logic data_oe;
    logic in_cyc;
    logic done;
  } ebc_pins_t;

endpackage

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int STRB_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       hold_n,
  input  logic       rdy_n,
  output ebc_state_e st_nxt,
  output logic       accept,
  output logic       cap_rd
);

  localparam int CW = $clog2(STRB_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STRB_CLKS - 1);

  ebc_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic min_met;

  assign min_met = (cnt_q >= LAST);

  always_comb begin
    st_nxt = st_q;
    accept = 1'b0;
    cap_rd = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!hold_n) begin
          st_nxt = ST_HOLD;
        end else if (req_valid) begin
          st_nxt = ST_ADDR;
          accept = 1'b1;
        end
      end
      ST_ADDR: st_nxt = ST_STRB;
      ST_STRB: begin
        if (min_met && rdy_n) begin
          st_nxt = ST_TERM;
          cap_rd = 1'b1;
        end
      end
      ST_TERM: st_nxt = ST_IDLE;
      ST_HOLD: if (hold_n) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q == ST_STRB) begin
        if (!min_met) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode #(
  parameter int HI_W = 8,
  parameter int NCS  = 4
) (
  input  logic [HI_W-1:0]     page,
  input  logic [NCS*HI_W-1:0] base,
  input  logic [NCS*HI_W-1:0] mask,
  output logic [NCS-1:0]      sel
);

  logic [NCS-1:0] hit;

  for (genvar i = 0; i < NCS; i++) begin : g_win
    assign hit[i] = ((page & mask[i*HI_W +: HI_W]) == base[i*HI_W +: HI_W]);
  end

  // lowest set bit wins
  assign sel = hit & (~hit + 1'b1);

endmodule

// File: rtl/ebc_strobe_enc.sv
module ebc_strobe_enc
  import ebc_pkg::*;
(
  input  ebc_state_e st,
  input  ebc_ctl_t   ctl,
  output ebc_pins_t  pins
);

  logic strb, in_cyc, wr_strb;

  assign strb    = (st == ST_STRB);
  assign in_cyc  = (st == ST_ADDR) || (st == ST_STRB) || (st == ST_TERM);
  assign wr_strb = strb && ctl.write;

  always_comb begin
    pins.rd_n    = !(strb && !ctl.write);
    pins.ale     = (st == ST_ADDR);
    pins.hlda_n  = (st != ST_HOLD);
    pins.bus_oe  = (st != ST_HOLD);
    pins.data_oe = in_cyc && ctl.write;
    pins.in_cyc  = in_cyc;
    pins.done    = (st == ST_TERM);
    if (ctl.combined) begin
      pins.wlo_n = !wr_strb;
      pins.whi_n = !(in_cyc && ctl.be[1]);
    end else begin
      pins.wlo_n = !(wr_strb && ctl.be[0]);
      pins.whi_n = !(wr_strb && ctl.be[1]);
    end
  end

endmodule

// File: rtl/ext_bus_strobe_ctrl.sv
module ext_bus_strobe_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int HI_W      = 8,
  parameter int NCS       = 4,
  parameter int STRB_CLKS = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_write,
  input  logic                   req_word,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   cfg_combined,
  input  logic [NCS*HI_W-1:0]    win_base,
  input  logic [NCS*HI_W-1:0]    win_mask,
  input  logic                   hold_n,
  input  logic                   rdy_n,
  input  logic [DATA_W-1:0]      bus_din,
  output logic                   done,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_n,
  output logic                   wr_lo_n,
  output logic                   wr_hi_n,
  output logic                   ale,
  output logic [NCS-1:0]         cs_n,
  output logic [HI_W-1:0]        a_hi,
  output logic [ADDR_W-HI_W-1:0] a_lo,
  output logic [DATA_W-1:0]      bus_dout,
  output logic                   addr_oe,
  output logic                   data_oe,
  output logic                   strb_oe,
  output logic                   hlda_n
);

  localparam int LO_W = ADDR_W - HI_W;
  localparam logic [HI_W-1:0] A_HI_RST = {1'b1, {(HI_W-1){1'b0}}};

  ebc_state_e       st_nxt;
  logic             accept, cap_rd;
  logic [ADDR_W-1:0] addr_q, addr_cur;
  logic [DATA_W-1:0] wdata_q, wdata_cur;
  ebc_ctl_t         ctl_q, ctl_in, ctl_cur;
  ebc_pins_t        pins;
  logic [NCS-1:0]   sel;

  ebc_seq #(.STRB_CLKS(STRB_CLKS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .hold_n   (hold_n),
    .rdy_n    (rdy_n),
    .st_nxt   (st_nxt),
    .accept   (accept),
    .cap_rd   (cap_rd)
  );

  always_comb begin
    ctl_in.write    = req_write;
    ctl_in.combined = cfg_combined;
    ctl_in.be       = req_word ? 2'b11 : (req_addr[0] ? 2'b10 : 2'b01);
  end

  assign addr_cur  = accept ? req_addr  : addr_q;
  assign wdata_cur = accept ? req_wdata : wdata_q;
  assign ctl_cur   = accept ? ctl_in    : ctl_q;

  ebc_strobe_enc u_enc (
    .st  (st_nxt),
    .ctl (ctl_cur),
    .pins(pins)
  );

  ebc_cs_decode #(.HI_W(HI_W), .NCS(NCS)) u_dec (
    .page(addr_cur[ADDR_W-1 -: HI_W]),
    .base(win_base),
    .mask(win_mask),
    .sel (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      ctl_q    <= '0;
      done     <= 1'b0;
      rd_data  <= '0;
      rd_n     <= 1'b1;
      wr_lo_n  <= 1'b1;
      wr_hi_n  <= 1'b1;
      ale      <= 1'b0;
      cs_n     <= '1;
      a_hi     <= A_HI_RST;
      a_lo     <= '0;
      bus_dout <= '0;
      addr_oe  <= 1'b1;
      data_oe  <= 1'b0;
      strb_oe  <= 1'b1;
      hlda_n   <= 1'b1;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        ctl_q   <= ctl_in;
      end
      if (cap_rd && !ctl_q.write) rd_data <= bus_din;
      done     <= pins.done;
      rd_n     <= pins.rd_n;
      wr_lo_n  <= pins.wlo_n;
      wr_hi_n  <= pins.whi_n;
      ale      <= pins.ale;
      cs_n     <= pins.in_cyc ? ~sel : '1;
      a_hi     <= {~addr_cur[ADDR_W-1], addr_cur[ADDR_W-2 -: HI_W-1]};
      a_lo     <= addr_cur[LO_W-1:0];
      bus_dout <= wdata_cur;
      addr_oe  <= pins.bus_oe;
      strb_oe  <= pins.bus_oe;
      data_oe  <= pins.data_oe;
      hlda_n   <= pins.hlda_n;
    end
  end

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hold_n,
  input logic           rdy_n,
  input logic           done,
  input logic           rd_n,
  input logic           wr_lo_n,
  input logic           wr_hi_n,
  input logic           ale,
  input logic [NCS-1:0] cs_n,
  input logic           addr_oe,
  input logic           data_oe,
  input logic           strb_oe,
  input logic           hlda_n
);

  // R2: address phase is one clock, followed by an active strobe
  p_ale_then_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && (!rd_n || !wr_lo_n || !wr_hi_n)));

  // R5: a read strobe never coincides with a write strobe
  p_read_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> wr_lo_n);

  // R6: a sampled wait keeps the read strobe low
  p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !rdy_n) |=> !rd_n);

  // R7: bus released and quiet while acknowledged
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !hlda_n |-> (!addr_oe && !data_oe && !strb_oe && rd_n && wr_lo_n
                 && wr_hi_n && (&cs_n) && !ale));

  // R8: grant only from idle with hold requested
  p_grant_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hlda_n) |-> $past(!hold_n && (&cs_n) && !done));

  // R10: at most one chip select active
  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R11: completion is a single-clock pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind ext_bus_strobe_ctrl ebc_checker #(.NCS(NCS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .hold_n (hold_n),
  .rdy_n  (rdy_n),
  .done   (done),
  .rd_n   (rd_n),
  .wr_lo_n(wr_lo_n),
  .wr_hi_n(wr_hi_n),
  .ale    (ale),
  .cs_n   (cs_n),
  .addr_oe(addr_oe),
  .data_oe(data_oe),
  .strb_oe(strb_oe),
  .hlda_n (hlda_n)
);

// File: tb/test_ext_bus_strobe_ctrl.sv
module test_ext_bus_strobe_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        cfg_combined = 1'b0;
  logic [31:0] win_base = {8'h00, 8'hC0, 8'h10, 8'h00};
  logic [31:0] win_mask = {8'hC0, 8'hC0, 8'hF0, 8'hF0};
  logic        hold_n = 1'b1;
  logic        rdy_n = 1'b1;
  logic [15:0] bus_din = '0;
  logic        done;
  logic [15:0] rd_data;
  logic        rd_n, wr_lo_n, wr_hi_n, ale;
  logic [3:0]  cs_n;
  logic [7:0]  a_hi;
  logic [15:0] a_lo;
  logic [15:0] bus_dout;
  logic        addr_oe, data_oe, strb_oe, hlda_n;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ext_bus_strobe_ctrl i_ext_bus_strobe_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .cfg_combined(cfg_combined), .win_base(win_base), .win_mask(win_mask),
    .hold_n(hold_n), .rdy_n(rdy_n), .bus_din(bus_din), .done(done),
    .rd_data(rd_data), .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
    .ale(ale), .cs_n(cs_n), .a_hi(a_hi), .a_lo(a_lo), .bus_dout(bus_dout),
    .addr_oe(addr_oe), .data_oe(data_oe), .strb_oe(strb_oe), .hlda_n(hlda_n)
  );

  typedef struct packed {
    logic [23:0] addr;
    logic        wr;
    logic        word;
    logic        comb;
    logic [15:0] data;
    logic [1:0]  waits;
    logic        lo;
    logic        hi;
    logic        rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{24'h000100, 1'b1, 1'b0, 1'b0, 16'h00A5, 2'd0, 1'b0, 1'b1, 1'b1},
    '{24'h100101, 1'b1, 1'b0, 1'b0, 16'h5A00, 2'd0, 1'b1, 1'b0, 1'b1},
    '{24'h200200, 1'b1, 1'b1, 1'b0, 16'h1234, 2'd0, 1'b0, 1'b0, 1'b1},
    '{24'h800010, 1'b0, 1'b1, 1'b0, 16'hBEEF, 2'd0, 1'b1, 1'b1, 1'b0},
    '{24'h8A0000, 1'b1, 1'b0, 1'b1, 16'h0033, 2'd0, 1'b0, 1'b1, 1'b1},
    '{24'h400003, 1'b1, 1'b0, 1'b1, 16'h4400, 2'd0, 1'b0, 1'b0, 1'b1},
    '{24'hFF0001, 1'b0, 1'b0, 1'b1, 16'h7700, 2'd0, 1'b1, 1'b0, 1'b0},
    '{24'h0F0000, 1'b0, 1'b0, 1'b0, 16'h0042, 2'd2, 1'b1, 1'b1, 1'b0},
    '{24'hC80002, 1'b1, 1'b1, 1'b1, 16'hCAFE, 2'd1, 1'b0, 1'b0, 1'b1},
    '{24'h300001, 1'b0, 1'b0, 1'b0, 16'h9900, 2'd3, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(input logic [23:0] a);
    logic [7:0] pg;
    pg = a[23:16];
    if (pg[7:4] == 4'h0)      return 4'b1110;
    else if (pg[7:4] == 4'h1) return 4'b1101;
    else if (pg[7:6] == 2'b11) return 4'b1011;
    else if (pg[7:6] == 2'b00) return 4'b0111;
    return 4'b1111;
  endfunction

  task automatic drive_req(input vec_t v);
    req_addr     = v.addr;
    req_write    = v.wr;
    req_word     = v.word;
    req_wdata    = v.data;
    cfg_combined = v.comb;
    bus_din      = v.data;
    req_valid    = 1'b1;
  endtask

  task automatic do_cycle(input vec_t v);
    @(negedge clk);
    drive_req(v);
    rdy_n = (v.waits == 2'd0);
    @(negedge clk);
    check(ale == 1'b1, "R2 ale in address phase", ale, 1);
    check(a_lo == v.addr[15:0], "R2 low address", a_lo, v.addr[15:0]);
    check(a_hi == {~v.addr[23], v.addr[22:16]}, "R9 high address", a_hi,
          {~v.addr[23], v.addr[22:16]});
    check(cs_n == exp_cs(v.addr), "R10 chip select", cs_n, exp_cs(v.addr));
    @(negedge clk);
    check(ale == 1'b0, "R2 ale one clock", ale, 0);
    check({wr_lo_n, wr_hi_n, rd_n} == {v.lo, v.hi, v.rd},
          "R3 R4 R5 strobe levels", {wr_lo_n, wr_hi_n, rd_n}, {v.lo, v.hi, v.rd});
    for (int i = 0; i < int'(v.waits); i++) begin
      @(negedge clk);
      check({wr_lo_n, wr_hi_n, rd_n, done} == {v.lo, v.hi, v.rd, 1'b0},
            "R6 wait stretches strobe", {wr_lo_n, wr_hi_n, rd_n, done},
            {v.lo, v.hi, v.rd, 1'b0});
      if (i == int'(v.waits) - 1) rdy_n = 1'b1;
    end
    @(negedge clk);
    check(done == 1'b1, "R11 done in terminate", done, 1);
    check(rd_n && wr_lo_n, "R5 strobes released", {rd_n, wr_lo_n}, 2'b11);
    check(cs_n == exp_cs(v.addr), "R10 chip select held", cs_n, exp_cs(v.addr));
    if (!v.wr) check(rd_data == v.data, "R5 read data", rd_data, v.data);
    req_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R11 done single clock", done, 0);
    check(cs_n == 4'hF, "R10 chip select idle", cs_n, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({rd_n, wr_lo_n, wr_hi_n, ale, done} == 5'b11100, "R1 reset strobes",
          {rd_n, wr_lo_n, wr_hi_n, ale, done}, 5'b11100);
    check({cs_n, hlda_n, addr_oe, strb_oe, data_oe} == 8'b1111_1110,
          "R1 reset selects and enables", {cs_n, hlda_n, addr_oe, strb_oe, data_oe},
          8'b1111_1110);
    rst = 1'b0;
    @(negedge clk);
    check({rd_n, wr_lo_n, wr_hi_n, ale, hlda_n} == 5'b11101, "R1 idle after reset",
          {rd_n, wr_lo_n, wr_hi_n, ale, hlda_n}, 5'b11101);

    for (int k = 0; k < NV; k++) do_cycle(VECS[k]);

    // R7: hold from idle, priority over a pending request
    @(negedge clk);
    hold_n = 1'b0;
    @(negedge clk);
    check({hlda_n, addr_oe, strb_oe, data_oe} == 4'b0000, "R7 hold granted",
          {hlda_n, addr_oe, strb_oe, data_oe}, 4'b0000);
    drive_req(VECS[0]);
    @(negedge clk);
    check({ale, cs_n, rd_n, wr_lo_n, wr_hi_n} == 8'b0_1111_111, "R7 hold quiet",
          {ale, cs_n, rd_n, wr_lo_n, wr_hi_n}, 8'b0_1111_111);
    hold_n = 1'b1;
    @(negedge clk);
    check({hlda_n, ale} == 2'b10, "R7 hold released to idle", {hlda_n, ale}, 2'b10);
    @(negedge clk);
    check(ale == 1'b1, "R7 request after release", ale, 1);
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b1, "R11 done after hold", done, 1);
    req_valid = 1'b0;
    @(negedge clk);

    // R8: hold arriving in the address phase waits for the boundary
    @(negedge clk);
    drive_req(VECS[3]);
    @(negedge clk);
    check(ale == 1'b1, "R8 address phase", ale, 1);
    hold_n = 1'b0;
    @(negedge clk);
    check({hlda_n, rd_n} == 2'b10, "R8 strobe continues", {hlda_n, rd_n}, 2'b10);
    @(negedge clk);
    check({hlda_n, done} == 2'b11, "R8 access completes", {hlda_n, done}, 2'b11);
    req_valid = 1'b0;
    @(negedge clk);
    check(hlda_n == 1'b1, "R8 idle before grant", hlda_n, 1);
    @(negedge clk);
    check(hlda_n == 1'b0, "R8 grant after boundary", hlda_n, 0);
    hold_n = 1'b1;
    repeat (2) @(negedge clk);
    check(hlda_n == 1'b1, "R7 released", hlda_n, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule